// File: doc/BRIEF.md
# Lane write-enable mask generator

This combinational unit sits in front of a lane-parallel vector ALU that works on one 64-byte row. It takes a 3-bit enable mode, a 6-bit mode value N and a 4-bit lane-width code. From these it produces a 32-bit per-lane enable vector and a small set of side flags. The side flags are a request to broadcast one Y lane to every lane, together with the index of that lane, and three overrides that force the result, the X operand or the Y operand to zero.

The lane width sets how many lanes the row holds: 32 lanes of 16 bits, 16 lanes of 32 bits, or 8 lanes of 64 bits. One width code selects 16-bit X/Y lanes with a double-width accumulator, and that choice is reported on its own output. Enable bits at or above the active lane count are always low. The ALU downstream writes only the lanes whose bit is set.

Top module: `lanemask_gen`

## Requirements
- R1: Width code 3 gives 32 lanes and raises accWide; code 4 gives 16 lanes; code 7 gives 8 lanes; every other code gives 32 lanes. accWide is low for every code other than 3.
- R2: laneEn bits at index equal to or above the active lane count are always 0.
- R3: Mode 0 with N=0 enables every lane. N=1 enables only odd-index lanes and N=2 only even-index lanes, where lane 0 counts as even.
- R4: Mode 0 with N=3, N=4 or N=5 enables every lane and raises zeroRes, zeroX or zeroY respectively, one flag only. Mode 0 with N of 6 or more enables no lane.
- R5: Mode 1 enables every lane and raises bcastY. bcastIdx equals N modulo the lane count.
- R6: Mode 2 enables lanes 0..N-1, and every lane when N=0.
- R7: Mode 3 enables the N highest-index lanes, and every lane when N=0.
- R8: Modes 4 and 5 enable the lowest N or the highest N lanes respectively, and no lane when N=0.
- R9: In modes 2 to 5, an N equal to or greater than the lane count enables every lane.
- R10: Modes 6 and 7 enable no lane. bcastY is raised only in mode 1, and zeroRes, zeroX and zeroY only in mode 0. bcastIdx is 0 outside mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enMode | input | 3 | Enable mode selector |
| enValue | input | 6 | Mode value N |
| widthSel | input | 4 | Lane-width code |
| laneEn | output | 32 | Per-lane enable, bit i for lane i |
| accWide | output | 1 | 16-bit X/Y lanes with double-width accumulator |
| bcastY | output | 1 | Broadcast one Y lane to all lanes |
| bcastIdx | output | 5 | Y lane to broadcast |
| zeroRes | output | 1 | Force the ALU result to zero |
| zeroX | output | 1 | Force X operands to zero |
| zeroY | output | 1 | Force Y operands to zero |

## Verification
The bench targets several corner cases, and each one exposes a distinct fault:
- N=0, where modes 2 and 3 must open every lane but modes 4 and 5 must open none. A design that shares one decode for both pairs inverts one of them.
- N equal to and just below the lane count at every width. An off-by-one in the head or tail comparison drops or adds an edge lane. An unguarded subtraction for the tail makes it wrap to a near-empty mask.
- Odd/even parity counted from lane 0, and the clearing of bits above 8 or 16 lanes. A swapped parity or a missing width clamp shows up directly on laneEn.
- Every combination of mode, value and width code, which catches override flags leaking into the wrong mode.

// File: rtl/lanemask_pkg.sv
package lanemask_pkg;
  localparam int ROW_BYTES = 64;
  localparam int MIN_LANE_BYTES = 2;
  localparam int MAX_LANES = ROW_BYTES / MIN_LANE_BYTES;
  localparam int IDX_W = $clog2(MAX_LANES);
  localparam int CNT_W = IDX_W + 1;
  localparam int VAL_W = 6;
  localparam int MODE_W = 3;
  localparam int WSEL_W = 4;

  // Strobes handed from the decoder to the mask datapath.
  typedef struct packed {
    logic pickAll;
    logic pickOdd;
    logic pickEven;
    logic pickHead;
    logic pickTail;
    logic bcast;
    logic zeroRes;
    logic zeroX;
    logic zeroY;
  } maskCtrl_s;
endpackage

// File: rtl/lanemask_ctrl.sv
module lanemask_ctrl
  import lanemask_pkg::*;
(
  input  logic [MODE_W-1:0] enMode,
  input  logic [VAL_W-1:0]  enValue,
  input  logic [WSEL_W-1:0] widthSel,
  output maskCtrl_s         ctrl,
  output logic [CNT_W-1:0]  laneCount,
  output logic              accWide
);
  localparam logic [CNT_W-1:0] LANES16 = CNT_W'(ROW_BYTES / 2);
  localparam logic [CNT_W-1:0] LANES32 = CNT_W'(ROW_BYTES / 4);
  localparam logic [CNT_W-1:0] LANES64 = CNT_W'(ROW_BYTES / 8);

  logic valueZero;
  assign valueZero = (enValue == '0);

  always_comb begin
    accWide = 1'b0;
    case (widthSel)
      WSEL_W'(3): begin laneCount = LANES16; accWide = 1'b1; end
      WSEL_W'(4): laneCount = LANES32;
      WSEL_W'(7): laneCount = LANES64;
      default:    laneCount = LANES16;
    endcase
  end

  always_comb begin
    ctrl = '0;
    case (enMode)
      MODE_W'(0): begin
        case (enValue)
          VAL_W'(0): ctrl.pickAll = 1'b1;
          VAL_W'(1): ctrl.pickOdd = 1'b1;
          VAL_W'(2): ctrl.pickEven = 1'b1;
          VAL_W'(3): begin ctrl.pickAll = 1'b1; ctrl.zeroRes = 1'b1; end
          VAL_W'(4): begin ctrl.pickAll = 1'b1; ctrl.zeroX = 1'b1; end
          VAL_W'(5): begin ctrl.pickAll = 1'b1; ctrl.zeroY = 1'b1; end
          default:   ;
        endcase
      end
      MODE_W'(1): begin ctrl.pickAll = 1'b1; ctrl.bcast = 1'b1; end
      MODE_W'(2): begin ctrl.pickAll = valueZero; ctrl.pickHead = !valueZero; end
      MODE_W'(3): begin ctrl.pickAll = valueZero; ctrl.pickTail = !valueZero; end
      MODE_W'(4): ctrl.pickHead = !valueZero;
      MODE_W'(5): ctrl.pickTail = !valueZero;
      default:    ;
    endcase
  end
endmodule

// File: rtl/lanemask_dp.sv
module lanemask_dp
  import lanemask_pkg::*;
(
  input  maskCtrl_s            ctrl,
  input  logic [CNT_W-1:0]     laneCount,
  input  logic [VAL_W-1:0]     enValue,
  output logic [MAX_LANES-1:0] laneEn,
  output logic [IDX_W-1:0]     bcastIdx
);
  logic [MAX_LANES-1:0] validMask;
  logic [MAX_LANES-1:0] oddMask;
  logic [MAX_LANES-1:0] headMask;
  logic [MAX_LANES-1:0] tailMask;
  logic [MAX_LANES-1:0] rawMask;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    localparam logic [VAL_W:0] LANE_IDX = (VAL_W + 1)'(i);
    assign validMask[i] = (LANE_IDX < {1'b0, laneCount});
    assign oddMask[i]   = LANE_IDX[0];
    // Head: lane index below N. Tail: index + N reaches the lane count.
    assign headMask[i]  = (LANE_IDX < {1'b0, enValue});
    assign tailMask[i]  = ((LANE_IDX + {1'b0, enValue}) >= {1'b0, laneCount});
  end

  always_comb begin
    rawMask = '0;
    if (ctrl.pickAll)  rawMask = rawMask | {MAX_LANES{1'b1}};
    if (ctrl.pickOdd)  rawMask = rawMask | oddMask;
    if (ctrl.pickEven) rawMask = rawMask | ~oddMask;
    if (ctrl.pickHead) rawMask = rawMask | headMask;
    if (ctrl.pickTail) rawMask = rawMask | tailMask;
  end

  assign laneEn = rawMask & validMask;

  logic [IDX_W-1:0] idxWrap;
  assign idxWrap  = IDX_W'(laneCount - 1'b1);
  assign bcastIdx = ctrl.bcast ? (enValue[IDX_W-1:0] & idxWrap) : '0;
endmodule

// File: rtl/lanemask_gen.sv
module lanemask_gen
  import lanemask_pkg::*;
(
  input  logic [2:0]  enMode,
  input  logic [5:0]  enValue,
  input  logic [3:0]  widthSel,
  output logic [31:0] laneEn,
  output logic        accWide,
  output logic        bcastY,
  output logic [4:0]  bcastIdx,
  output logic        zeroRes,
  output logic        zeroX,
  output logic        zeroY
);
  maskCtrl_s        ctrl;
  logic [CNT_W-1:0] laneCount;

  lanemask_ctrl ctrl_i (
    .enMode    (enMode),
    .enValue   (enValue),
    .widthSel  (widthSel),
    .ctrl      (ctrl),
    .laneCount (laneCount),
    .accWide   (accWide)
  );

  lanemask_dp dp_i (
    .ctrl      (ctrl),
    .laneCount (laneCount),
    .enValue   (enValue),
    .laneEn    (laneEn),
    .bcastIdx  (bcastIdx)
  );

  assign bcastY  = ctrl.bcast;
  assign zeroRes = ctrl.zeroRes;
  assign zeroX   = ctrl.zeroX;
  assign zeroY   = ctrl.zeroY;
endmodule

// File: rtl/lanemask_gen_chk.sv
module lanemask_gen_chk (
  input logic [2:0]  enMode,
  input logic [5:0]  enValue,
  input logic [3:0]  widthSel,
  input logic [31:0] laneEn,
  input logic        accWide,
  input logic        bcastY,
  input logic [4:0]  bcastIdx,
  input logic        zeroRes,
  input logic        zeroX,
  input logic        zeroY
);
  int lanes;
  logic known;
  always_comb begin
    lanes = (widthSel == 4'd4) ? 16 : (widthSel == 4'd7) ? 8 : 32;
    known = !$isunknown({enMode, enValue, widthSel});
  end

  always_comb begin
    if (known) begin
      AST_ABOVE_LANES_ZERO: assert ((laneEn >> lanes) == 32'd0); // R2
      AST_WIDE_ONLY_CODE3: assert (accWide == (widthSel == 4'd3)); // R1
      AST_ODD_NO_EVEN: assert (!(enMode == 3'd0 && enValue == 6'd1) || (laneEn & 32'h5555_5555) == 32'd0); // R3
      AST_ONE_OVERRIDE: assert ($onehot0({zeroRes, zeroX, zeroY, bcastY})); // R4
      AST_BCAST_ALL_LANES: assert (!bcastY || $countones(laneEn) == lanes); // R5
      AST_HEAD_COUNT: assert (!(enMode == 3'd2 && enValue != 6'd0 && int'(enValue) < lanes) || $countones(laneEn) == int'(enValue)); // R6
      AST_TAIL_TOP_LANE: assert (!(enMode == 3'd3) || laneEn[lanes-1]); // R7
      AST_IDLE_MODES: assert (!(enMode >= 3'd6) || laneEn == 32'd0); // R10
      AST_FLAGS_IN_MODE: assert ((!bcastY || enMode == 3'd1) && (!(zeroRes || zeroX || zeroY) || enMode == 3'd0)); // R10
    end
  end
endmodule

bind lanemask_gen lanemask_gen_chk chk_i (
  .enMode   (enMode),
  .enValue  (enValue),
  .widthSel (widthSel),
  .laneEn   (laneEn),
  .accWide  (accWide),
  .bcastY   (bcastY),
  .bcastIdx (bcastIdx),
  .zeroRes  (zeroRes),
  .zeroX    (zeroX),
  .zeroY    (zeroY)
);

// File: tb/lanemask_gen_tb_top.sv
`timescale 1ns/1ps
module lanemask_gen_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]  enMode;
  logic [5:0]  enValue;
  logic [3:0]  widthSel;
  logic [31:0] laneEn;
  logic        accWide, bcastY, zeroRes, zeroX, zeroY;
  logic [4:0]  bcastIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  lanemask_gen dut_i (
    .enMode(enMode), .enValue(enValue), .widthSel(widthSel),
    .laneEn(laneEn), .accWide(accWide), .bcastY(bcastY), .bcastIdx(bcastIdx),
    .zeroRes(zeroRes), .zeroX(zeroX), .zeroY(zeroY)
  );

  function automatic int lanesOf(input logic [3:0] w);
    if (w == 4'd4) return 16;
    if (w == 4'd7) return 8;
    return 32;
  endfunction

  // Expected mask built from the requirements, lane by lane.
  function automatic logic [31:0] expMask(input logic [2:0] m, input logic [5:0] v, input logic [3:0] w);
    int n = lanesOf(w);
    int nv = int'(v);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) begin
      logic on = 1'b0;
      case (m)
        3'd0: on = (nv == 0 || nv == 3 || nv == 4 || nv == 5) ? 1'b1 :
                   (nv == 1) ? (i % 2 == 1) : (nv == 2) ? (i % 2 == 0) : 1'b0;
        3'd1: on = 1'b1;
        3'd2: on = (nv == 0) || (i < nv);
        3'd3: on = (nv == 0) || (i >= n - nv);
        3'd4: on = (nv != 0) && (i < nv);
        3'd5: on = (nv != 0) && (i >= n - nv);
        default: on = 1'b0;
      endcase
      r[i] = on;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d val=%0d wsel=%0d got=%h exp=%h", tag, enMode, enValue, widthSel, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] m, input logic [5:0] v, input logic [3:0] w);
    @(negedge clk);
    enMode = m; enValue = v; widthSel = w;
    #1;
  endtask

  task automatic t_reset_state();
    apply(3'd0, 6'd0, 4'd0);
    chk("R3 idle all", laneEn, 32'hFFFF_FFFF);
    chk("R10 idle flags", {27'd0, bcastY, zeroRes, zeroX, zeroY, accWide}, 32'd0);
  endtask

  task automatic t_width();
    apply(3'd0, 6'd0, 4'd3); chk("R1 code3 mask", laneEn, 32'hFFFF_FFFF); chk("R1 code3 wide", {31'd0, accWide}, 32'd1);
    apply(3'd0, 6'd0, 4'd4); chk("R1 code4 mask", laneEn, 32'h0000_FFFF); chk("R1 code4 wide", {31'd0, accWide}, 32'd0);
    apply(3'd0, 6'd0, 4'd7); chk("R1 code7 mask", laneEn, 32'h0000_00FF);
    apply(3'd0, 6'd0, 4'd15); chk("R1 code15 mask", laneEn, 32'hFFFF_FFFF); chk("R1 code15 wide", {31'd0, accWide}, 32'd0);
    apply(3'd1, 6'd0, 4'd7); chk("R2 upper bits", laneEn & 32'hFFFF_FF00, 32'd0);
  endtask

  task automatic t_parity();
    apply(3'd0, 6'd1, 4'd0); chk("R3 odd", laneEn, 32'hAAAA_AAAA);
    apply(3'd0, 6'd2, 4'd0); chk("R3 even", laneEn, 32'h5555_5555);
    apply(3'd0, 6'd2, 4'd7); chk("R3 even 8", laneEn, 32'h0000_0055);
  endtask

  task automatic t_overrides();
    apply(3'd0, 6'd3, 4'd4); chk("R4 zres", {28'd0, zeroRes, zeroX, zeroY, bcastY}, 32'b1000); chk("R4 zres mask", laneEn, 32'h0000_FFFF);
    apply(3'd0, 6'd4, 4'd0); chk("R4 zx", {28'd0, zeroRes, zeroX, zeroY, bcastY}, 32'b0100);
    apply(3'd0, 6'd5, 4'd0); chk("R4 zy", {28'd0, zeroRes, zeroX, zeroY, bcastY}, 32'b0010);
    apply(3'd0, 6'd6, 4'd0); chk("R4 none", laneEn, 32'd0);
  endtask

  task automatic t_bcast();
    apply(3'd1, 6'd9, 4'd0); chk("R5 flag", {31'd0, bcastY}, 32'd1); chk("R5 idx", {27'd0, bcastIdx}, 32'd9);
    apply(3'd1, 6'd9, 4'd7); chk("R5 idx wrap", {27'd0, bcastIdx}, 32'd1); chk("R5 mask", laneEn, 32'h0000_00FF);
    apply(3'd2, 6'd9, 4'd0); chk("R10 idx zero", {26'd0, bcastY, bcastIdx}, 32'd0);
  endtask

  task automatic t_counts();
    apply(3'd2, 6'd0, 4'd4); chk("R6 N0 all", laneEn, 32'h0000_FFFF);
    apply(3'd2, 6'd5, 4'd0); chk("R6 first5", laneEn, 32'h0000_001F);
    apply(3'd3, 6'd0, 4'd7); chk("R7 N0 all", laneEn, 32'h0000_00FF);
    apply(3'd3, 6'd3, 4'd4); chk("R7 last3", laneEn, 32'h0000_E000);
    apply(3'd4, 6'd0, 4'd0); chk("R8 N0 none", laneEn, 32'd0);
    apply(3'd5, 6'd0, 4'd0); chk("R8 N0 none tail", laneEn, 32'd0);
    apply(3'd5, 6'd1, 4'd0); chk("R8 last1", laneEn, 32'h8000_0000);
    apply(3'd4, 6'd7, 4'd7); chk("R9 below", laneEn, 32'h0000_007F);
    apply(3'd4, 6'd8, 4'd7); chk("R9 equal", laneEn, 32'h0000_00FF);
    apply(3'd5, 6'd63, 4'd4); chk("R9 large tail", laneEn, 32'h0000_FFFF);
    apply(3'd6, 6'd0, 4'd0); chk("R10 mode6", laneEn, 32'd0);
    apply(3'd7, 6'd5, 4'd0); chk("R10 mode7", laneEn, 32'd0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 8; m++)
      for (int v = 0; v < 64; v++)
        for (int w = 0; w < 16; w++) begin
          logic [3:0] expFlags;
          apply(3'(m), 6'(v), 4'(w));
          chk("R2 R6 R7 R8 R9 sweep", laneEn, expMask(3'(m), 6'(v), 4'(w)));
          expFlags = {(m == 0 && v == 3), (m == 0 && v == 4), (m == 0 && v == 5), (m == 1)};
          chk("R10 sweep flags", {28'd0, zeroRes, zeroX, zeroY, bcastY}, {28'd0, expFlags});
        end
  endtask

  initial begin
    enMode = '0; enValue = '0; widthSel = '0;
    t_reset_state();
    t_width();
    t_parity();
    t_overrides();
    t_bcast();
    t_counts();
    t_sweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule